// File: doc/BRIEF.md
# Paged Configuration Register Bank

This block holds the 8-bit configuration and status registers of a display-processing chip. A serial slave front end delivers each register access as an 8-bit subaddress with a write strobe or a read strobe. The bank divides its registers into twelve numbered pages, one page per functional unit. A global window at the top of the subaddress space, F8h to FFh, is always reachable. The register at FFh holds the page number. Every subaddress below F8h is decoded against that page number, so only the registers of the active page can be reached.

On each page, subaddresses 00h to 03h are writable configuration registers. The downstream unit that owns the page reads them from a flat output bus. Subaddresses 80h and 81h of each page are read-only and return status or measurement bytes from the functional units. Global subaddresses F8h to FBh are writable registers that all pages share. The low two bits of page 0, register 03h, choose the spike filter mode of the serial input and are also brought out on a port of their own. Reads are combinational in the cycle of the read strobe. Writes take effect at the clock edge.

Top module: `paged_reg_bank`

## Requirements
- R1: After reset, the page register, all configuration registers and all global registers read 00h.
- R2: Global registers at F8h to FBh are written and read back the same way, whatever page is active.
- R3: Subaddress FFh stores all 8 bits written to it and reads them back. Its value also appears on page_o and holds until the next write to FFh.
- R4: A write to FFh takes effect for the access in the very next cycle.
- R5: When the page is 0 to 11, subaddresses 00h to 03h reach configuration register (page, subaddress). That register is cfg_o byte page*4+subaddress, in bits [8*k+7:8*k]. A write changes only that register.
- R6: When the page is 0 to 11, a read of 80h+k (k = 0 or 1) returns status_i byte page*2+k.
- R7: When the page value is 12 or more, reads below F8h return 00h and writes below F8h change nothing.
- R8: Writes to status subaddresses or to unmapped subaddresses (04h to 7Fh, 82h to F7h, FCh to FEh) change no register. Reads of unmapped subaddresses return 00h.
- R9: spike_mode_o equals bits [1:0] of configuration register 03h on page 0.
- R10: rdata_o is 00h in any cycle where rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register subaddress |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, combinational |
| status_i | input | 192 | Read-only status bytes, page*2+k |
| page_o | output | 8 | Active page number |
| cfg_o | output | 384 | Configuration bytes, page*4+index |
| glb_o | output | 32 | Global register bytes |
| spike_mode_o | output | 2 | Serial input spike filter mode |

## Verification
The hardest states to reach are those in which the page register changes between two accesses one cycle apart, or holds a value from 12 to 255. In those states the same subaddress must hit a different register, or hit nothing at all. The random stimulus writes FFh often, and about a quarter of those writes carry an out-of-range page. Directed sequences write a page and then access it in the very next cycle. They also write and read through a bad page and then confirm, via cfg_o and via reads after returning to a valid page, that no register changed.

// File: rtl/prb_pkg.sv
package prb_pkg;
  typedef struct packed {
    logic       glb;
    logic       page_ok;
    logic       cfg_hit;
    logic       stat_hit;
    logic [7:0] off;
  } prb_dec_t;
endpackage

// File: rtl/prb_decode.sv
module prb_decode
  import prb_pkg::*;
#(
  parameter int          NUM_PAGES = 12,
  parameter int          CFG_REGS  = 4,
  parameter int          STAT_REGS = 2,
  parameter logic [7:0]  STAT_BASE = 8'h80
) (
  input  logic [7:0] addr_i,
  input  logic [7:0] page_i,
  output prb_dec_t   dec_o
);
  localparam logic [7:0] PAGE_LIM = 8'(NUM_PAGES);
  localparam logic [7:0] CFG_LIM  = 8'(CFG_REGS);
  localparam logic [7:0] STAT_LIM = 8'(STAT_REGS);

  logic [7:0] stat_off;
  assign stat_off = addr_i - STAT_BASE;

  always_comb begin
    dec_o          = '0;
    dec_o.glb      = (addr_i[7:3] == 5'b11111);
    dec_o.page_ok  = (page_i < PAGE_LIM);
    dec_o.cfg_hit  = !dec_o.glb && dec_o.page_ok && (addr_i < CFG_LIM);
    dec_o.stat_hit = !dec_o.glb && dec_o.page_ok && (addr_i >= STAT_BASE) && (stat_off < STAT_LIM);
    dec_o.off      = dec_o.stat_hit ? stat_off : addr_i;
  end
endmodule

// File: rtl/prb_cfg_page.sv
module prb_cfg_page #(
  parameter int N  = 4,
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] idx_i,
  input  logic [7:0]    wdata_i,
  output logic [N*8-1:0] regs_o
);
  logic [7:0] mem [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we_i) begin
      for (int i = 0; i < N; i++)
        if (int'(idx_i) == i) mem[i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign regs_o[g*8 +: 8] = mem[g];
  end

  p_cfg_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_o));
endmodule

// File: rtl/paged_reg_bank.sv
module paged_reg_bank
  import prb_pkg::*;
#(
  parameter int         NUM_PAGES = 12,
  parameter int         CFG_REGS  = 4,
  parameter int         STAT_REGS = 2,
  parameter logic [7:0] STAT_BASE = 8'h80,
  parameter int         GLB_REGS  = 4   // at most 7, FFh is the page register
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [7:0]                        addr_i,
  input  logic [7:0]                        wdata_i,
  input  logic                              wr_i,
  input  logic                              rd_i,
  output logic [7:0]                        rdata_o,
  input  logic [NUM_PAGES*STAT_REGS*8-1:0]  status_i,
  output logic [7:0]                        page_o,
  output logic [NUM_PAGES*CFG_REGS*8-1:0]   cfg_o,
  output logic [GLB_REGS*8-1:0]             glb_o,
  output logic [1:0]                        spike_mode_o
);
  localparam int         CW        = (CFG_REGS > 1) ? $clog2(CFG_REGS) : 1;
  localparam int         NCFG      = NUM_PAGES * CFG_REGS;
  localparam int         NSTAT     = NUM_PAGES * STAT_REGS;
  localparam logic [7:0] PAGE_ADDR = 8'hFF;
  localparam logic [7:0] PAGE_LIM  = 8'(NUM_PAGES);

  prb_dec_t         dec;
  logic [7:0]       page_q;
  logic [7:0]       glb_q [GLB_REGS];
  logic [NUM_PAGES-1:0] page_we;
  logic [7:0]       cfg_b  [NCFG];
  logic [7:0]       stat_b [NSTAT];

  prb_decode #(
    .NUM_PAGES(NUM_PAGES), .CFG_REGS(CFG_REGS),
    .STAT_REGS(STAT_REGS), .STAT_BASE(STAT_BASE)
  ) u_dec (
    .addr_i(addr_i), .page_i(page_q), .dec_o(dec)
  );

  // global window: page register and shared registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      for (int i = 0; i < GLB_REGS; i++) glb_q[i] <= '0;
    end else if (wr_i && dec.glb) begin
      if (addr_i == PAGE_ADDR) page_q <= wdata_i;
      for (int i = 0; i < GLB_REGS; i++)
        if (int'(addr_i[2:0]) == i) glb_q[i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    assign page_we[p] = wr_i && dec.cfg_hit && (page_q == 8'(p));
    prb_cfg_page #(.N(CFG_REGS), .CW(CW)) u_page (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (page_we[p]),
      .idx_i  (dec.off[CW-1:0]),
      .wdata_i(wdata_i),
      .regs_o (cfg_o[p*CFG_REGS*8 +: CFG_REGS*8])
    );
  end

  for (genvar c = 0; c < NCFG; c++) begin : g_cfgb
    assign cfg_b[c] = cfg_o[c*8 +: 8];
  end
  for (genvar s = 0; s < NSTAT; s++) begin : g_statb
    assign stat_b[s] = status_i[s*8 +: 8];
  end
  for (genvar g = 0; g < GLB_REGS; g++) begin : g_glb
    assign glb_o[g*8 +: 8] = glb_q[g];
  end

  always_comb begin
    int cfg_sel, stat_sel;
    cfg_sel  = int'(page_q) * CFG_REGS + int'(dec.off);
    stat_sel = int'(page_q) * STAT_REGS + int'(dec.off);
    rdata_o  = '0;
    if (rd_i) begin
      if (dec.glb) begin
        if (addr_i == PAGE_ADDR) rdata_o = page_q;
        for (int i = 0; i < GLB_REGS; i++)
          if (int'(addr_i[2:0]) == i) rdata_o = glb_q[i];
      end else if (dec.cfg_hit) begin
        for (int i = 0; i < NCFG; i++)
          if (cfg_sel == i) rdata_o = cfg_b[i];
      end else if (dec.stat_hit) begin
        for (int i = 0; i < NSTAT; i++)
          if (stat_sel == i) rdata_o = stat_b[i];
      end
    end
  end

  assign page_o       = page_q;
  assign spike_mode_o = cfg_b[3][1:0];

  p_page_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == PAGE_ADDR |=> page_o == $past(wdata_i));
  p_page_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == PAGE_ADDR) |=> $stable(page_o));
  p_page_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == PAGE_ADDR |-> rdata_o == page_o);
  p_bad_page_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && page_o >= PAGE_LIM && addr_i < 8'hF8 |-> rdata_o == 8'h00);
  p_bad_page_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_o >= PAGE_LIM |=> $stable(cfg_o));
  p_idle_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == 8'h00);
  p_one_page_we_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(page_we));
endmodule

// File: tb/paged_reg_bank_bench.sv
`timescale 1ns/1ps
module paged_reg_bank_bench;
  localparam int NP = 12, NC = 4, NS = 2, NG = 4;

  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic wr = 0, rd = 0;
  logic [7:0] rdata, page;
  logic [NP*NS*8-1:0] status = '0;
  logic [NP*NC*8-1:0] cfg;
  logic [NG*8-1:0] glb;
  logic [1:0] spike;

  int checks = 0, errors = 0;
  logic [7:0] m_cfg [NP][NC];
  logic [7:0] m_glb [NG];
  logic [7:0] m_page;

  always #2.5 clk = ~clk;

  paged_reg_bank u_paged_reg_bank (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .status_i(status),
    .page_o(page), .cfg_o(cfg), .glb_o(glb), .spike_mode_o(spike)
  );

  task automatic check(string req, logic [NP*NC*8-1:0] act, logic [NP*NC*8-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    if (a == 8'hFF) return m_page;
    if (a >= 8'hF8) return (a - 8'hF8 < NG) ? m_glb[a - 8'hF8] : 8'h00;
    if (m_page >= NP) return 8'h00;
    if (a < NC) return m_cfg[m_page][a];
    if (a >= 8'h80 && a < 8'h80 + NS) return status[(int'(m_page)*NS + int'(a - 8'h80))*8 +: 8];
    return 8'h00;
  endfunction

  function automatic logic [NP*NC*8-1:0] exp_cfg();
    logic [NP*NC*8-1:0] v;
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < NC; i++) v[(p*NC+i)*8 +: 8] = m_cfg[p][i];
    return v;
  endfunction

  task automatic do_wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
    if (a == 8'hFF) m_page = d;
    else if (a >= 8'hF8) begin if (a - 8'hF8 < NG) m_glb[a - 8'hF8] = d; end
    else if (m_page < NP && a < NC) m_cfg[m_page][a] = d;
  endtask

  task automatic do_rd(logic [7:0] a, string req);
    @(negedge clk); addr = a; rd = 1; #1;
    check(req, rdata, exp_rd(a));
    rd = 0;
  endtask

  task automatic check_state(string req);
    check(req, cfg, exp_cfg());
    check({req, " page"}, page, m_page);
    check("R9 spike", spike, m_cfg[0][3][1:0]);
  endtask

  initial begin
    #20000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    for (int p = 0; p < NP; p++) for (int i = 0; i < NC; i++) m_cfg[p][i] = 0;
    for (int i = 0; i < NG; i++) m_glb[i] = 0;
    m_page = 0;
    for (int i = 0; i < NP*NS; i++) status[i*8 +: 8] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 cfg", cfg, '0);
    check("R1 glb", glb, '0);
    check("R1 page", page, '0);
    do_rd(8'hFF, "R1 page read");
    // R10 idle read
    @(negedge clk); addr = 8'hFF; #1; check("R10 idle", rdata, 8'h00);
    // R9 spike filter
    do_wr(8'h03, 8'hA6); check_state("R9");
    // R4 page write then immediate access
    @(negedge clk); addr = 8'hFF; wdata = 8'd5; wr = 1;
    @(negedge clk); addr = 8'h02; wdata = 8'h5C; m_page = 5;
    @(negedge clk); wr = 0; m_cfg[5][2] = 8'h5C;
    check_state("R4");
    do_rd(8'h02, "R4 read");
    // R6 status on page 5
    do_rd(8'h80, "R6"); do_rd(8'h81, "R6");
    // R2 globals across pages
    do_wr(8'hF9, 8'h3D); do_wr(8'hFF, 8'd11); do_rd(8'hF9, "R2");
    // R7 bad page
    do_wr(8'hFF, 8'd12); do_wr(8'h01, 8'hEE); do_rd(8'h01, "R7");
    do_rd(8'h80, "R7 stat"); check_state("R7");
    do_wr(8'hFF, 8'hFE); do_rd(8'hFF, "R3"); do_rd(8'h00, "R7");
    // R8 unmapped and read-only writes
    do_wr(8'hFF, 8'd0); do_wr(8'h80, 8'h11); do_wr(8'h40, 8'h22); do_wr(8'hFD, 8'h33);
    check_state("R8"); do_rd(8'h40, "R8"); do_rd(8'hFD, "R8"); do_rd(8'h80, "R8 ro");
    check("R8 glb", glb, {m_glb[3], m_glb[2], m_glb[1], m_glb[0]});
    // random mix, R5 and the rest
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      int sel = $urandom_range(0, 9);
      case (sel)
        0, 1, 2: a = 8'($urandom_range(0, NC-1));
        3: a = 8'h80 + 8'($urandom_range(0, 2));
        4: a = 8'hF8 + 8'($urandom_range(0, 6));
        5: a = 8'hFF;
        default: a = 8'($urandom);
      endcase
      if (n % 50 == 0) for (int i = 0; i < NP*NS; i++) status[i*8 +: 8] = 8'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        logic [7:0] d = 8'($urandom);
        if (a == 8'hFF) d = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(12, 255)) : 8'($urandom_range(0, 11));
        do_wr(a, d);
        if (n % 10 == 0) check_state("R5");
      end else do_rd(a, "R5 random");
    end
    check_state("R5 final");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule